// File: doc/BRIEF.md
# Accumulator Instruction Sequencer with Interrupt Check

This block is a small accumulator machine. It keeps a program counter, an instruction register and a 16-bit accumulator. It talks to a single synchronous memory through one port that serves both instructions and data. Read data returns one cycle after the read strobe. Each instruction goes through a fetch phase and an execute phase. After every executed instruction there is an explicit interrupt-check phase.

An instruction word is 16 bits: the top 4 bits are the opcode and the low 12 bits are an address. The opcodes are:

| Opcode | Instruction |
|---|---|
| 0x1 | Load into the accumulator |
| 0x2 | Store the accumulator |
| 0x5 | Add into the accumulator |
| 0xE | Return from the handler |
| 0xF | Halt |

Every other opcode acts as a no-op.

When a request is taken, the core copies the program counter and the accumulator into shadow registers. It then masks further requests and jumps to a handler address fixed by a parameter. The return instruction copies both values back and unmasks.

The FSM states and transitions are:

- FETCH → FETCH_WAIT (read at PC).
- FETCH_WAIT → EXEC (instruction register loaded, PC incremented).
- EXEC → OPERAND for a load or an add (operand read issued).
- EXEC → INT_CHECK for a store, a return or an unknown opcode.
- EXEC → HALT for a halt.
- OPERAND → INT_CHECK (accumulator updated).
- INT_CHECK → FETCH. In this transition the request is either taken (vector and save) or passed over.
- HALT stays in HALT until reset.

Top module: `acc_seq_core`

## Requirements
- R1: Reset clears the PC, the accumulator and the mask, and enters FETCH: busy=1, halted=0, no write strobe and no acknowledge. In the first cycle after reset, the core reads address 0.
- R2: Instructions execute in address order. A load or an add takes 5 cycles (FETCH, FETCH_WAIT, EXEC, OPERAND, INT_CHECK). A store takes 4 cycles. Halt reaches HALT at the end of its EXEC cycle.
- R3: Opcode 0x1 copies the word at its 12-bit address into the accumulator.
- R4: Opcode 0x5 adds the word at its address to the accumulator, modulo 2^16.
- R5: Opcode 0x2 writes the accumulator to its address with exactly one write-strobe cycle. Read and write strobes are never active together.
- R6: Opcode 0xF enters HALT: halted=1 and busy=0. In HALT there are no further memory accesses, and a request is never acknowledged, until reset.
- R7: The request input is sampled only in INT_CHECK. If it is high and unmasked, irq_ack pulses for that one cycle and the next fetch reads HANDLER_ADDR (default 0x100).
- R8: Opcode 0xE restores the saved PC and accumulator. The interrupted program resumes at the instruction after the one completed before the request was taken, with its accumulator intact.
- R9: While the handler runs, requests are masked. A request held high through the handler is not acknowledged again before the return.
- R10: Any opcode other than 0x1, 0x2, 0x5, 0xE and 0xF changes neither the accumulator nor memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Interrupt request, level |
| mem_rdata | input | 16 | Memory read data, valid one cycle after mem_rd_en |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| irq_ack | output | 1 | One-cycle acknowledge when a request is taken |
| busy | output | 1 | High while not halted |
| halted | output | 1 | High in HALT |

## Verification
The bench holds the request high until the handler has issued its store. A core that ignored the mask would acknowledge twice and re-enter the handler. The handler overwrites the accumulator, so a return that failed to restore it would store the handler's value into the main program's result words. An add that wraps past 0xFFFF, an unknown opcode between a load and a store, and a request raised after halt are each checked: a core that got one wrong would store a wrong sum, alter memory, or start fetching again. The exact cycle at which the core halts is counted, which exposes any extra or missing state in a phase.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OPC_LOAD  = 4'h1;
    localparam logic [OP_W-1:0] OPC_STORE = 4'h2;
    localparam logic [OP_W-1:0] OPC_ADD   = 4'h5;
    localparam logic [OP_W-1:0] OPC_RETI  = 4'hE;
    localparam logic [OP_W-1:0] OPC_HALT  = 4'hF;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_FETCH_WAIT,
        ST_EXEC,
        ST_OPERAND,
        ST_INT_CHECK,
        ST_HALT
    } seq_state_t;

endpackage

// File: rtl/acc_seq_ctx.sv
module acc_seq_ctx #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] acc_in,
    output logic [AW-1:0] pc_saved,
    output logic [DW-1:0] acc_saved
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_saved  <= '0;
            acc_saved <= '0;
        end else if (save) begin
            pc_saved  <= pc_in;
            acc_saved <= acc_in;
        end
    end

endmodule

// File: rtl/acc_seq_alu.sv
module acc_seq_alu #(
    parameter int DW = 16
) (
    input  logic          do_add,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] operand,
    output logic [DW-1:0] result
);

    always_comb begin
        if (do_add) result = acc + operand;
        else        result = operand;
    end

endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
    import acc_seq_pkg::*;
#(
    parameter int              AW           = 12,
    parameter logic [AW-1:0]   HANDLER_ADDR = 12'h100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 irq_req,
    input  logic [OP_W+AW-1:0]   mem_rdata,
    output logic                 mem_rd_en,
    output logic                 mem_wr_en,
    output logic [AW-1:0]        mem_addr,
    output logic [OP_W+AW-1:0]   mem_wdata,
    output logic                 irq_ack,
    output logic                 busy,
    output logic                 halted
);

    localparam int DW = OP_W + AW;

    seq_state_t      state_q, state_d;
    logic [AW-1:0]   pc_q;
    logic [DW-1:0]   ir_q;
    logic [DW-1:0]   acc_q;
    logic            mask_q;
    logic [OP_W-1:0] opcode;
    logic [AW-1:0]   operand_addr;
    logic            take_irq;
    logic            do_reti;
    logic [AW-1:0]   pc_saved;
    logic [DW-1:0]   acc_saved;
    logic [DW-1:0]   alu_result;

    assign opcode       = ir_q[DW-1:AW];
    assign operand_addr = ir_q[AW-1:0];
    assign take_irq     = (state_q == ST_INT_CHECK) && irq_req && !mask_q;
    assign do_reti      = (state_q == ST_EXEC) && (opcode == OPC_RETI);

    acc_seq_ctx #(.AW(AW), .DW(DW)) ctx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .save      (take_irq),
        .pc_in     (pc_q),
        .acc_in    (acc_q),
        .pc_saved  (pc_saved),
        .acc_saved (acc_saved)
    );

    acc_seq_alu #(.DW(DW)) alu_i (
        .do_add  (opcode == OPC_ADD),
        .acc     (acc_q),
        .operand (mem_rdata),
        .result  (alu_result)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH:      state_d = ST_FETCH_WAIT;
            ST_FETCH_WAIT: state_d = ST_EXEC;
            ST_EXEC: begin
                unique case (opcode)
                    OPC_LOAD, OPC_ADD: state_d = ST_OPERAND;
                    OPC_HALT:          state_d = ST_HALT;
                    default:           state_d = ST_INT_CHECK;
                endcase
            end
            ST_OPERAND:    state_d = ST_INT_CHECK;
            ST_INT_CHECK:  state_d = ST_FETCH;
            ST_HALT:       state_d = ST_HALT;
            default:       state_d = ST_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    // architectural registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q   <= '0;
            ir_q   <= '0;
            acc_q  <= '0;
            mask_q <= 1'b0;
        end else begin
            if (state_q == ST_FETCH_WAIT) begin
                ir_q <= mem_rdata;
                pc_q <= pc_q + 1'b1;
            end
            if (state_q == ST_OPERAND) acc_q <= alu_result;
            if (do_reti) begin
                pc_q   <= pc_saved;
                acc_q  <= acc_saved;
                mask_q <= 1'b0;
            end
            if (take_irq) begin
                pc_q   <= HANDLER_ADDR;
                mask_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        mem_addr  = pc_q;
        mem_wdata = acc_q;
        unique case (state_q)
            ST_FETCH: mem_rd_en = 1'b1;
            ST_EXEC: begin
                mem_addr = operand_addr;
                if (opcode == OPC_LOAD || opcode == OPC_ADD) mem_rd_en = 1'b1;
                if (opcode == OPC_STORE)                     mem_wr_en = 1'b1;
            end
            default: ;
        endcase
        irq_ack = take_irq;
        halted  = (state_q == ST_HALT);
        busy    = (state_q != ST_HALT);
    end

    // assertions
    a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    a_r6_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !mem_rd_en && !mem_wr_en && !irq_ack));

    a_r7_vector: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (mem_rd_en && mem_addr == HANDLER_ADDR));

    a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> mask_q);

    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH_WAIT) |=> (pc_q == $past(pc_q) + 1'b1));

    a_r8_reti_restore: assert property (@(posedge clk) disable iff (!rst_n)
        do_reti |=> (pc_q == $past(pc_saved) && acc_q == $past(acc_saved) && !mask_q));

endmodule

// File: tb/acc_seq_core_tb_top.sv
`timescale 1ns/1ps
module acc_seq_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0;
    logic [15:0] mem_rdata;
    logic        mem_rd_en, mem_wr_en, irq_ack, busy, halted;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;

    int n_checks = 0;
    int n_errors = 0;
    int n_access = 0;
    int n_acks   = 0;

    logic [15:0] mem [0:511];

    always #10 clk = ~clk;

    acc_seq_core dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req   (irq_req),
        .mem_rdata (mem_rdata),
        .mem_rd_en (mem_rd_en),
        .mem_wr_en (mem_wr_en),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .irq_ack   (irq_ack),
        .busy      (busy),
        .halted    (halted)
    );

    always @(posedge clk) begin
        if (mem_wr_en) mem[mem_addr[8:0]] <= mem_wdata;
        if (mem_rd_en) mem_rdata <= mem[mem_addr[8:0]];
        if (rst_n && (mem_rd_en || mem_wr_en)) n_access++;
        if (rst_n && irq_ack) n_acks++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 512; i++) mem[i] = 16'h0000;
    endtask

    task automatic start();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_halt(output int cycles);
        cycles = 0;
        while (!halted && cycles < 2000) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic t_reset();
        clear_mem();
        mem[0] = 16'hF000;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(busy == 1'b1 && halted == 1'b0, "R1", "busy/halted in reset", {busy, halted}, 2'b10);
        check(mem_wr_en == 1'b0 && irq_ack == 1'b0, "R1", "no write/ack in reset", {mem_wr_en, irq_ack}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        check(mem_rd_en == 1'b1 && mem_addr == 12'h000, "R1", "first fetch address", mem_addr, 0);
    endtask

    task automatic t_load_add_store();
        int cyc;
        int acc0;
        clear_mem();
        mem[0] = 16'h1040; mem[1] = 16'h5041; mem[2] = 16'h2042; mem[3] = 16'hF000;
        mem[9'h40] = 16'h1234; mem[9'h41] = 16'h0101;
        start();
        acc0 = n_access;
        wait_halt(cyc);
        check(cyc == 17, "R2", "cycles to halt", cyc, 17);
        check(mem[9'h42] == 16'h1335, "R4", "load+add stored sum", mem[9'h42], 16'h1335);
        check(mem[9'h40] == 16'h1234, "R3", "load source kept", mem[9'h40], 16'h1234);
        // 4 fetches + 2 operand reads + 1 write
        check(n_access - acc0 == 7, "R5", "access count incl. one write strobe", n_access - acc0, 7);
        check(halted == 1'b1 && busy == 1'b0, "R6", "halted/busy", {halted, busy}, 2'b10);
    endtask

    task automatic t_wrap_add();
        int cyc;
        clear_mem();
        mem[0] = 16'h1060; mem[1] = 16'h2062; mem[2] = 16'h5061; mem[3] = 16'h2063; mem[4] = 16'hF000;
        mem[9'h60] = 16'hFFFF; mem[9'h61] = 16'h0003;
        start();
        wait_halt(cyc);
        check(mem[9'h62] == 16'hFFFF, "R3", "loaded value stored", mem[9'h62], 16'hFFFF);
        check(mem[9'h63] == 16'h0002, "R4", "add wraps", mem[9'h63], 16'h0002);
    endtask

    task automatic t_unknown_op();
        int cyc;
        clear_mem();
        mem[0] = 16'h1070; mem[1] = 16'h7071; mem[2] = 16'h2072; mem[3] = 16'hF000;
        mem[9'h70] = 16'hBEEF; mem[9'h71] = 16'h0123;
        start();
        wait_halt(cyc);
        check(mem[9'h72] == 16'hBEEF, "R10", "acc unchanged by unknown opcode", mem[9'h72], 16'hBEEF);
        check(mem[9'h71] == 16'h0123, "R10", "memory unchanged by unknown opcode", mem[9'h71], 16'h0123);
    endtask

    task automatic t_halt_sticky();
        int a0, k0;
        a0 = n_access; k0 = n_acks;
        irq_req = 1'b1;
        repeat (12) @(negedge clk);
        irq_req = 1'b0;
        check(n_access == a0, "R6", "no access after halt", n_access - a0, 0);
        check(n_acks == k0, "R6", "no ack after halt", n_acks - k0, 0);
        check(halted == 1'b1, "R6", "still halted", halted, 1);
    endtask

    task automatic t_interrupt();
        int cyc, k0, n;
        clear_mem();
        mem[0] = 16'h1040; mem[1] = 16'h2043; mem[2] = 16'h2044; mem[3] = 16'hF000;
        mem[9'h40] = 16'h0AAA; mem[9'h50] = 16'h5555;
        mem[9'h100] = 16'h1050; mem[9'h101] = 16'h2051; mem[9'h102] = 16'hE000;
        start();
        k0 = n_acks;
        irq_req = 1'b1;
        n = 0;
        while (!irq_ack && n < 50) begin @(negedge clk); n++; end
        check(n == 4, "R7", "ack in INT_CHECK after first load", n, 4);
        @(negedge clk);
        check(mem_rd_en == 1'b1 && mem_addr == 12'h100, "R7", "fetch from handler", mem_addr, 12'h100);
        n = 0;
        while (!(mem_wr_en && mem_addr == 12'h051) && n < 50) begin @(negedge clk); n++; end
        check(n_acks - k0 == 1, "R9", "single ack while masked", n_acks - k0, 1);
        irq_req = 1'b0;
        wait_halt(cyc);
        check(mem[9'h51] == 16'h5555, "R7", "handler ran", mem[9'h51], 16'h5555);
        check(mem[9'h43] == 16'h0AAA, "R8", "acc restored after return", mem[9'h43], 16'h0AAA);
        check(mem[9'h44] == 16'h0AAA, "R8", "program resumed in order", mem[9'h44], 16'h0AAA);
        check(n_acks - k0 == 1, "R9", "no re-entry", n_acks - k0, 1);
    endtask

    initial begin
        clear_mem();
        t_reset();
        t_load_add_store();
        t_halt_sticky();
        t_wrap_add();
        t_unknown_op();
        t_interrupt();
        t_halt_sticky();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule